// File: doc/BRIEF.md
# Power-Fail Chip-Enable Conditioner

This block steers one active-low chip-enable onto one of several active-low bank enables for a memory that keeps its contents on battery power. Two select bits pick the bank. While the supply is good, the chosen enable follows the chip-enable input directly, with no clock stage in the path. The other enables stay high.

An external comparator reports a failing supply as a digital flag. There are two such flags, one for each tolerance level, and a threshold-select pin picks which one is used. When a failure is seen and no access is under way, every enable goes high at once. When an access is under way, that access may finish on the bank it started on. If it is still running after a programmable number of clock edges, all enables are forced high anyway.

The block leaves the protected state only after two conditions meet at a clock edge: the selected flag is low and the chip-enable input is high. Reset also places the block in the protected state, so an access cannot start partway through a cycle while power returns.

Top module: `pf_ce_cond`

## Requirements
- R1: While `rst_n` is low, all four bits of `bank_ce_n` are 1 (inactive), and the block is in the protected state.
- R2: In normal operation, `bank_ce_n[i]` equals `ce_n` when `bank_sel` holds the binary value i (0 to 3). Every other bit is 1.
- R3: In normal operation, `bank_ce_n` follows changes on `ce_n` and `bank_sel` within the same clock cycle, with no clock edge in between.
- R4: If the selected fail flag is sampled high at a clock edge while `ce_n` is high, all outputs are 1 from that edge onward.
- R5: If the selected fail flag is sampled high at a clock edge while `ce_n` is low, the bank selected at that edge keeps following `ce_n`. This lasts until `ce_n` is high (all outputs are then 1). Changes on `bank_sel` in this period have no effect.
- R6: If `ce_n` stays low for GRACE_CYCLES clock edges after the detection edge, all outputs are 1 from that edge onward.
- R7: Once the protected state is entered, a new low level on `ce_n` never drives any output to 0, whatever `bank_sel` holds.
- R8: The protected state is left only at a clock edge where the selected fail flag is low and `ce_n` is high. With `ce_n` held low, all outputs stay 1.
- R9: With `thr_sel` = 0, `fail_narrow` is the fail flag. With `thr_sel` = 1, `fail_wide` is the fail flag. The unselected flag has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the protection state and the grace timer |
| rst_n | input | 1 | Asynchronous active-low reset, enters the protected state |
| ce_n | input | 1 | Active-low chip-enable request |
| bank_sel | input | 2 | Binary bank index |
| thr_sel | input | 1 | 0 uses `fail_narrow`, 1 uses `fail_wide` |
| fail_narrow | input | 1 | Supply-fail flag for the tight tolerance level |
| fail_wide | input | 1 | Supply-fail flag for the loose tolerance level |
| bank_ce_n | output | 4 | Conditioned active-low bank enables |

## Verification
The assertions assume that `ce_n`, `bank_sel`, `thr_sel` and both fail flags are synchronous to `clk` and stable around its rising edge. They also assume that the chip-enable input is not sampled high during a drain and then pulled low again before the next edge. The bench keeps to these assumptions by changing every input only a few nanoseconds after a rising edge. It holds each input steady through the next edge and reads the outputs before that edge.

// File: rtl/pf_ce_pkg.sv
package pf_ce_pkg;
  typedef enum logic [1:0] {
    PF_RUN   = 2'd0,
    PF_DRAIN = 2'd1,
    PF_LOCK  = 2'd2
  } pf_state_e;
endpackage

// File: rtl/pf_ce_decode.sv
module pf_ce_decode #(
  parameter int NUM_BANKS = 4,
  localparam int SEL_W = $clog2(NUM_BANKS)
) (
  input  logic                 en_i,
  input  logic                 ce_n_i,
  input  logic [SEL_W-1:0]     sel_i,
  output logic [NUM_BANKS-1:0] ce_n_o
);
  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    assign ce_n_o[i] = ~(en_i & ~ce_n_i & (sel_i == SEL_W'(i)));
  end
endmodule

// File: rtl/pf_ce_grace.sv
module pf_ce_grace #(
  parameter int GRACE_CYCLES = 8,
  localparam int CNT_W = $clog2(GRACE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic run_i,
  output logic expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (load_i)                cnt_q <= CNT_W'(GRACE_CYCLES);
    else if (run_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // R6
  timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(GRACE_CYCLES));
  // R6
  timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/pf_ce_ctrl.sv
module pf_ce_ctrl
  import pf_ce_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int SEL_W = $clog2(NUM_BANKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n_i,
  input  logic             fail_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             expired_i,
  output pf_state_e        st_o,
  output logic [SEL_W-1:0] held_sel_o,
  output logic             load_o
);
  pf_state_e        st_q, st_d;
  logic [SEL_W-1:0] held_q;

  always_comb begin
    st_d   = st_q;
    load_o = 1'b0;
    unique case (st_q)
      PF_RUN: if (fail_i) begin
        if (!ce_n_i) begin
          st_d   = PF_DRAIN;
          load_o = 1'b1;
        end else begin
          st_d = PF_LOCK;
        end
      end
      PF_DRAIN: if (ce_n_i || expired_i) st_d = PF_LOCK;
      PF_LOCK:  if (!fail_i && ce_n_i)   st_d = PF_RUN;
      default:  st_d = PF_LOCK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PF_LOCK;
      held_q <= '0;
    end else begin
      st_q <= st_d;
      if (load_o) held_q <= sel_i;
    end
  end

  assign st_o       = st_q;
  assign held_sel_o = held_q;

  // R8
  unlock_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PF_RUN && $past(st_q) == PF_LOCK) |-> ($past(!fail_i) && $past(ce_n_i)));
  // R4
  idle_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PF_RUN && fail_i && ce_n_i) |=> (st_q == PF_LOCK));
  // R5
  drain_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PF_DRAIN && $past(st_q) == PF_RUN) |-> (held_q == $past(sel_i)));
endmodule

// File: rtl/pf_ce_cond.sv
module pf_ce_cond
  import pf_ce_pkg::*;
#(
  parameter int NUM_BANKS    = 4,
  parameter int GRACE_CYCLES = 8,
  localparam int SEL_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ce_n,
  input  logic [SEL_W-1:0]     bank_sel,
  input  logic                 thr_sel,
  input  logic                 fail_narrow,
  input  logic                 fail_wide,
  output logic [NUM_BANKS-1:0] bank_ce_n
);
  pf_state_e        st;
  logic [SEL_W-1:0] held_sel;
  logic             fail_act, load, expired, route_en;
  logic [SEL_W-1:0] route_sel;

  assign fail_act = thr_sel ? fail_wide : fail_narrow;

  pf_ce_ctrl #(.NUM_BANKS(NUM_BANKS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n_i     (ce_n),
    .fail_i     (fail_act),
    .sel_i      (bank_sel),
    .expired_i  (expired),
    .st_o       (st),
    .held_sel_o (held_sel),
    .load_o     (load)
  );

  pf_ce_grace #(.GRACE_CYCLES(GRACE_CYCLES)) u_grace (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load),
    .run_i     (st == PF_DRAIN),
    .expired_o (expired)
  );

  assign route_en  = (st == PF_RUN) || (st == PF_DRAIN && !expired);
  assign route_sel = (st == PF_DRAIN) ? held_sel : bank_sel;

  pf_ce_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
    .en_i   (route_en),
    .ce_n_i (ce_n),
    .sel_i  (route_sel),
    .ce_n_o (bank_ce_n)
  );

  // R2
  one_hot_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~bank_ce_n) <= 1);
  // R7
  lock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PF_LOCK) |-> (&bank_ce_n));
  // R6
  grace_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PF_DRAIN && expired) |-> (&bank_ce_n));
  // R2
  run_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PF_RUN && !ce_n) |-> (bank_ce_n[bank_sel] == 1'b0));
  // R5
  drain_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PF_DRAIN) |-> (bank_ce_n[held_sel] == (ce_n | expired)));
endmodule

// File: tb/pf_ce_cond_tb.sv
module pf_ce_cond_tb;
  localparam int G = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1;
  logic [1:0] bank_sel = 2'd0;
  logic       thr_sel = 1'b0;
  logic       fail_narrow = 1'b0;
  logic       fail_wide = 1'b0;
  logic [3:0] bank_ce_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pf_ce_cond #(.NUM_BANKS(4), .GRACE_CYCLES(G)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .bank_sel(bank_sel),
    .thr_sel(thr_sel), .fail_narrow(fail_narrow), .fail_wide(fail_wide),
    .bank_ce_n(bank_ce_n)
  );

  // {sel[1:0], ce_n, expected[3:0]}
  localparam logic [6:0] VEC [8] = '{
    {2'd0, 1'b0, 4'b1110}, {2'd0, 1'b1, 4'b1111},
    {2'd1, 1'b0, 4'b1101}, {2'd1, 1'b1, 4'b1111},
    {2'd2, 1'b0, 4'b1011}, {2'd2, 1'b1, 4'b1111},
    {2'd3, 1'b0, 4'b0111}, {2'd3, 1'b1, 4'b1111}
  };

  task automatic chk(input string req, input logic [3:0] exp);
    checks++;
    if (bank_ce_n !== exp) begin
      failures++;
      $display("FAIL %s: bank_ce_n=%b expected=%b at %0t", req, bank_ce_n, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset holds everything inactive even with ce_n low
    ce_n = 1'b0;
    repeat (3) tick();
    #1 chk("R1", 4'b1111);
    // R8: reset released with ce_n low stays protected
    rst_n = 1'b1;
    repeat (3) tick();
    #1 chk("R8", 4'b1111);
    ce_n = 1'b1;
    tick();

    // R2: walk every decoder code
    for (int i = 0; i < 8; i++) begin
      bank_sel = VEC[i][6:5];
      ce_n     = VEC[i][4];
      #1 chk("R2", VEC[i][3:0]);
      tick();
    end

    // R3: changes within one cycle with no edge between
    bank_sel = 2'd2; ce_n = 1'b0;
    #1 chk("R3", 4'b1011);
    bank_sel = 2'd0;
    #1 chk("R3", 4'b1110);
    ce_n = 1'b1;
    #1 chk("R3", 4'b1111);
    tick();

    // R9: unselected flag ignored
    thr_sel = 1'b0; fail_wide = 1'b1; bank_sel = 2'd1; ce_n = 1'b0;
    repeat (3) tick();
    #1 chk("R9", 4'b1101);
    ce_n = 1'b1; fail_wide = 1'b0;
    tick();

    // R4: fail with no access
    fail_narrow = 1'b1;
    tick();
    ce_n = 1'b0; bank_sel = 2'd2;
    #1 chk("R4", 4'b1111);
    tick();
    #1 chk("R7", 4'b1111);
    // R8: flag clears while ce_n still low
    fail_narrow = 1'b0;
    repeat (3) tick();
    #1 chk("R8", 4'b1111);
    ce_n = 1'b1;
    tick();
    ce_n = 1'b0;
    #1 chk("R8", 4'b1011);
    ce_n = 1'b1;
    tick();

    // R5: fail during access that ends inside the grace window
    bank_sel = 2'd3; ce_n = 1'b0;
    #1 chk("R2", 4'b0111);
    fail_narrow = 1'b1;
    #1 chk("R5", 4'b0111);
    tick();
    bank_sel = 2'd0;
    #1 chk("R5", 4'b0111);
    repeat (3) tick();
    #1 chk("R5", 4'b0111);
    ce_n = 1'b1;
    #1 chk("R5", 4'b1111);
    tick();
    ce_n = 1'b0;
    #1 chk("R7", 4'b1111);
    bank_sel = 2'd3;
    tick();
    #1 chk("R7", 4'b1111);
    ce_n = 1'b1; fail_narrow = 1'b0;
    tick();

    // R6: access outlasts the grace window, flag via thr_sel=1 (R9)
    thr_sel = 1'b1; fail_narrow = 1'b1;
    bank_sel = 2'd1; ce_n = 1'b0;
    #1 chk("R9", 4'b1101);
    fail_wide = 1'b1;
    tick();
    for (int k = 1; k <= G; k++) begin
      tick();
      #1 chk("R6", (k < G) ? 4'b1101 : 4'b1111);
    end
    repeat (3) tick();
    #1 chk("R6", 4'b1111);
    ce_n = 1'b1; fail_wide = 1'b0; fail_narrow = 1'b0;
    tick();
    ce_n = 1'b0; bank_sel = 2'd0;
    #1 chk("R8", 4'b1110);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule